// File: doc/BRIEF.md
# Per-Line Horizontal Dot Scroll Unit

This block computes a horizontal dot offset for each of four display line regions of a character display and uses it to translate a screen dot column into a source dot column. A host programs one 6-bit scroll code and a 4-bit line-enable mask through a write port. That port only accepts writes while an extended-register access gate is open. The display pipeline presents a line region and a dot column and receives the shifted source column one clock later. If the shifted column lies beyond the end of the line, it receives a blank flag instead.

The active line mode decides which enable bits belong to which line region. In one-line and two-line modes, pairs of bits act together. In four-line mode, each region has its own bit. Each region keeps its own applied offset register. In immediate mode that register follows its target at once. In smooth mode it walks toward the target by one dot per frame tick, so the picture glides instead of jumping.

Top module: `dhs_scroll_unit`

## Requirements
- R1: After reset the stored scroll code and enable mask are zero, every applied offset is zero, and `src_col` and `src_blank` are both 0.
- R2: A write (`wr_en`=1) changes state only while `ext_en`=1. With `ext_en`=0 the stored code and mask keep their values.
- R3: Scroll codes 0 to 47 give a left shift equal to their binary value, so code 0 gives no shift. Every code with bits [5:4]=2'b11 gives a 48-dot shift.
- R4: With `line_mode`=2'b10 or 2'b11 (four lines), region i scrolls only when mask bit i is set. Mask bit 0 belongs to region 0 and bit 3 to region 3.
- R5: With `line_mode`=2'b00 (one line), region 0 scrolls only when mask bits 0 and 1 are both set. Regions 1 to 3 never scroll.
- R6: With `line_mode`=2'b01 (two lines), region 0 needs mask bits 0 and 1 both set, and region 1 needs mask bits 2 and 3 both set. Regions 2 and 3 never scroll.
- R7: A region that is not enabled has an applied offset of 0 on the clock after it loses its enable, whatever the stored code and the smooth setting.
- R8: With `smooth_en`=0, an enabled region's applied offset equals its decoded target on the clock after the stored code or mask changes.
- R9: With `smooth_en`=1, an enabled region's applied offset moves one dot toward its target on each clock where `frame_tick`=1, and it holds on clocks without a tick.
- R10: `src_col` equals `rd_col` plus the applied offset of region `rd_line`. It is registered one clock after `rd_line` and `rd_col`.
- R11: When `rd_col` plus the offset exceeds DOTS_PER_LINE-1 (119 by default), `src_blank` is 1 and `src_col` is 0.
- R12: A write with `wr_sel`=0 loads the enable mask from `wr_data[3:0]`. A write with `wr_sel`=1 loads the scroll code from `wr_data[5:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extended-register access gate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: enable mask, 1: scroll code |
| wr_data | input | 6 | Write data |
| line_mode | input | 2 | 00 one line, 01 two lines, 1x four lines |
| smooth_en | input | 1 | 1: step the offset per frame tick |
| frame_tick | input | 1 | Frame strobe for smooth stepping |
| rd_line | input | 2 | Line region being fetched |
| rd_col | input | 7 | Screen dot column |
| src_col | output | 7 | Shifted source dot column |
| src_blank | output | 1 | Shifted column is past the line end |

## Verification
A write is captured at the first clock edge, and the region offsets follow it at the second edge. The column result that uses the new offset appears after the third edge. Writes and lookups are driven on falling edges, and the bench waits the matching number of edges before it samples. One directed test deliberately samples after two edges and after three edges. It expects the old offset first and the new offset second. Smooth-mode checks apply exactly one tick per step and read the offset through a column-0 lookup one edge after the step.

// File: rtl/dhs_scroll_pkg.sv
package dhs_scroll_pkg;

    localparam int QTY_W       = 6;
    localparam int MASK_W      = 4;
    localparam int NUM_REGIONS = 4;
    localparam int MAX_SHIFT   = 48;
    localparam int OFS_W       = $clog2(MAX_SHIFT + 1);

    typedef logic [OFS_W-1:0] ofs_t;

    // Saturating decode of the 6-bit code into a dot count.
    function automatic ofs_t decode_qty(input logic [QTY_W-1:0] code);
        if (code[QTY_W-1:QTY_W-2] == 2'b11) begin
            return ofs_t'(MAX_SHIFT);
        end
        return ofs_t'(code);
    endfunction

    // Which mask bits make a region scroll, per line mode.
    function automatic logic region_enable(input logic [1:0] mode,
                                           input logic [MASK_W-1:0] mask,
                                           input int idx);
        case (mode)
            2'b00:   return (idx == 0) && mask[0] && mask[1];
            2'b01:   return ((idx == 0) && mask[0] && mask[1]) ||
                            ((idx == 1) && mask[2] && mask[3]);
            default: return mask[idx];
        endcase
    endfunction

endpackage

// File: rtl/dhs_scroll_regs.sv
module dhs_scroll_regs
    import dhs_scroll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [QTY_W-1:0] wr_data_i,
    output logic [QTY_W-1:0] qty_o,
    output logic [MASK_W-1:0] mask_o
);

    typedef struct packed {
        logic [QTY_W-1:0]  qty;
        logic [MASK_W-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && ext_en_i) begin
            if (wr_sel_i) begin
                st_d.qty = wr_data_i;
            end else begin
                st_d.mask = wr_data_i[MASK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qty_o  = st_q.qty;
    assign mask_o = st_q.mask;

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en_i |=> ($stable(qty_o) && $stable(mask_o))); // R2

endmodule

// File: rtl/dhs_scroll_region.sv
module dhs_scroll_region
    import dhs_scroll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  ofs_t tgt_i,
    input  logic smooth_i,
    input  logic tick_i,
    output ofs_t ofs_o
);

    typedef struct packed {
        ofs_t ofs;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.ofs = '0;
        end else if (!smooth_i) begin
            st_d.ofs = tgt_i;
        end else if (tick_i) begin
            if (st_q.ofs < tgt_i) begin
                st_d.ofs = st_q.ofs + ofs_t'(1);
            end else if (st_q.ofs > tgt_i) begin
                st_d.ofs = st_q.ofs - ofs_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ofs_o = st_q.ofs;

    AST_OFS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_o <= ofs_t'(MAX_SHIFT)); // R3
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (ofs_o == '0)); // R7
    AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !smooth_i) |=> (ofs_o == $past(tgt_i))); // R8
    AST_SMOOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && smooth_i && !tick_i) |=> $stable(ofs_o)); // R9

endmodule

// File: rtl/dhs_scroll_colmap.sv
module dhs_scroll_colmap
    import dhs_scroll_pkg::*;
#(
    parameter int DOTS_PER_LINE = 120,
    localparam int COL_W = $clog2(DOTS_PER_LINE),
    localparam int SUM_W = $clog2(DOTS_PER_LINE + MAX_SHIFT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  line_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [NUM_REGIONS-1:0][OFS_W-1:0] ofs_i,
    output logic [COL_W-1:0]            src_o,
    output logic                        blank_o
);

    localparam int LAST_COL = DOTS_PER_LINE - 1;

    typedef struct packed {
        logic [COL_W-1:0] src;
        logic             blank;
    } map_t;

    map_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(col_i) + SUM_W'(ofs_i[line_i]);
        st_d = '0;
        if (sum > SUM_W'(LAST_COL)) begin
            st_d.blank = 1'b1;
        end else begin
            st_d.src = sum[COL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o   = st_q.src;
    assign blank_o = st_q.blank;

    AST_SRC_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |-> (src_o <= COL_W'(LAST_COL))); // R10
    AST_BLANK_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (src_o == '0)); // R11

endmodule

// File: rtl/dhs_scroll_unit.sv
module dhs_scroll_unit
    import dhs_scroll_pkg::*;
#(
    parameter int DOTS_PER_LINE = 120,
    localparam int COL_W = $clog2(DOTS_PER_LINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [QTY_W-1:0] wr_data,
    input  logic [1:0]       line_mode,
    input  logic             smooth_en,
    input  logic             frame_tick,
    input  logic [1:0]       rd_line,
    input  logic [COL_W-1:0] rd_col,
    output logic [COL_W-1:0] src_col,
    output logic             src_blank
);

    logic [QTY_W-1:0]  qty;
    logic [MASK_W-1:0] mask;
    ofs_t              tgt;
    logic [NUM_REGIONS-1:0] reg_en;
    logic [NUM_REGIONS-1:0][OFS_W-1:0] ofs;

    dhs_scroll_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en_i  (ext_en),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .qty_o     (qty),
        .mask_o    (mask)
    );

    assign tgt = decode_qty(qty);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        assign reg_en[g] = region_enable(line_mode, mask, g);

        dhs_scroll_region u_region (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (reg_en[g]),
            .tgt_i    (tgt),
            .smooth_i (smooth_en),
            .tick_i   (frame_tick),
            .ofs_o    (ofs[g])
        );
    end

    dhs_scroll_colmap #(
        .DOTS_PER_LINE (DOTS_PER_LINE)
    ) u_colmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rd_line),
        .col_i   (rd_col),
        .ofs_i   (ofs),
        .src_o   (src_col),
        .blank_o (src_blank)
    );

    AST_ONE_LINE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b00) |=> (ofs[1] == '0 || $past(line_mode) != 2'b00)); // R5
    AST_TWO_LINE_LOWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b01) |=> (ofs[2] == '0 && ofs[3] == '0)); // R6

endmodule

// File: tb/tb_dhs_scroll_unit.sv
`timescale 1ns/100ps
module tb_dhs_scroll_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [5:0] wr_data = '0;
    logic [1:0] line_mode = 2'b10;
    logic       smooth_en = 1'b0, frame_tick = 1'b0;
    logic [1:0] rd_line = '0;
    logic [6:0] rd_col = '0;
    logic [6:0] src_col;
    logic       src_blank;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dhs_scroll_unit dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .line_mode(line_mode),
        .smooth_en(smooth_en), .frame_tick(frame_tick), .rd_line(rd_line),
        .rd_col(rd_col), .src_col(src_col), .src_blank(src_blank)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] mask;
        logic [5:0] code;
        logic [1:0] line;
        logic [6:0] col;
        logic [6:0] exp_src;
        logic       exp_blank;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 4'hF,    6'd5,  2'd0, 7'd0,   7'd5,   1'b0}, // R4 R10
        '{2'b10, 4'hF,    6'd5,  2'd3, 7'd114, 7'd119, 1'b0}, // R11 edge
        '{2'b10, 4'hF,    6'd5,  2'd3, 7'd115, 7'd0,   1'b1}, // R11 past
        '{2'b10, 4'b0100, 6'd10, 2'd2, 7'd3,   7'd13,  1'b0}, // R4
        '{2'b10, 4'b0100, 6'd10, 2'd1, 7'd3,   7'd3,   1'b0}, // R4 R7
        '{2'b00, 4'b0011, 6'd47, 2'd0, 7'd0,   7'd47,  1'b0}, // R3 R5
        '{2'b00, 4'b0001, 6'd47, 2'd0, 7'd0,   7'd0,   1'b0}, // R5
        '{2'b00, 4'hF,    6'd48, 2'd1, 7'd2,   7'd2,   1'b0}, // R5
        '{2'b00, 4'hF,    6'd63, 2'd0, 7'd71,  7'd119, 1'b0}, // R3
        '{2'b00, 4'hF,    6'd63, 2'd0, 7'd72,  7'd0,   1'b1}, // R3 R11
        '{2'b01, 4'b1100, 6'd20, 2'd1, 7'd1,   7'd21,  1'b0}, // R6
        '{2'b01, 4'b1100, 6'd20, 2'd0, 7'd1,   7'd1,   1'b0}, // R6
        '{2'b01, 4'hF,    6'd20, 2'd2, 7'd1,   7'd1,   1'b0}, // R6
        '{2'b01, 4'hF,    6'd0,  2'd0, 7'd9,   7'd9,   1'b0}  // R3 zero
    };

    task automatic check(input string req, input int act_src, input int act_blank,
                         input int exp_src, input int exp_blank);
        checks++;
        if (act_src != exp_src || act_blank != exp_blank) begin
            errors++;
            $display("FAIL %s: src=%0d blank=%0d expected src=%0d blank=%0d",
                     req, act_src, act_blank, exp_src, exp_blank);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [5:0] data, input logic gate);
        @(negedge clk);
        ext_en = gate; wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; ext_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic lookup(input logic [1:0] line, input logic [6:0] col);
        rd_line = line; rd_col = col;
        @(negedge clk);
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", src_col, src_blank, 0, 0);
        rst_n = 1'b1;
        line_mode = 2'b10;
        write_reg(1'b1, 6'd9, 1'b1);
        settle();
        lookup(2'd0, 7'd4);
        check("R1 mask zero after reset", src_col, src_blank, 4, 0);

        for (int i = 0; i < NV; i++) begin
            line_mode = VECS[i].mode;
            write_reg(1'b0, {2'b00, VECS[i].mask}, 1'b1);
            write_reg(1'b1, VECS[i].code, 1'b1);
            settle();
            lookup(VECS[i].line, VECS[i].col);
            check($sformatf("vector %0d R3-R6/R10/R11", i), src_col, src_blank,
                  VECS[i].exp_src, VECS[i].exp_blank);
        end

        // R2 and R12: gated writes ignored
        line_mode = 2'b10;
        write_reg(1'b0, 6'h0F, 1'b1);
        write_reg(1'b1, 6'd7, 1'b1);
        write_reg(1'b1, 6'd30, 1'b0);
        write_reg(1'b0, 6'h00, 1'b0);
        settle();
        lookup(2'd0, 7'd0);
        check("R2 closed gate code/mask kept", src_col, src_blank, 7, 0);

        // R8 latency: old value after two edges, new after three
        rd_line = 2'd0; rd_col = 7'd0;
        @(negedge clk);
        ext_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 6'd12;
        @(negedge clk);
        wr_en = 1'b0; ext_en = 1'b0;
        @(negedge clk);
        check("R8 two edges still old", src_col, src_blank, 7, 0);
        @(negedge clk);
        check("R8 R10 three edges new", src_col, src_blank, 12, 0);

        // R9 smooth stepping
        smooth_en = 1'b1;
        write_reg(1'b1, 6'd15, 1'b1);
        settle(); settle();
        lookup(2'd0, 7'd0);
        check("R9 no tick holds", src_col, src_blank, 12, 0);
        tick();
        lookup(2'd0, 7'd0);
        check("R9 one tick", src_col, src_blank, 13, 0);
        tick(); tick(); tick(); tick();
        lookup(2'd0, 7'd0);
        check("R9 stops at target", src_col, src_blank, 15, 0);
        write_reg(1'b1, 6'd13, 1'b1);
        tick();
        lookup(2'd0, 7'd0);
        check("R9 steps down", src_col, src_blank, 14, 0);

        // R7 disable snaps to zero in smooth mode, re-enable ramps
        write_reg(1'b0, 6'h00, 1'b1);
        settle();
        lookup(2'd0, 7'd5);
        check("R7 disabled zero", src_col, src_blank, 5, 0);
        write_reg(1'b0, 6'h0F, 1'b1);
        tick();
        lookup(2'd0, 7'd5);
        check("R7 R9 ramp from zero", src_col, src_blank, 6, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule